// File: doc/BRIEF.md
# Timer/Counter with Assignable Prescaler

This block is a byte-addressed timer/counter that counts either an internal tick or an external count input, and it raises an overflow interrupt. The counter is 16 bits wide and has an 8-bit mode. Software sets the block up through four byte registers: the count low byte, the count high byte, a control byte and a status/enable byte.

An 8-bit prescaler counter sits between the selected event source and the counter. Software cannot read or write it. A control bit either routes events through the prescaler, which divides them by a power of two, or sends them straight to the counter. Software can flip that bit while the counter runs. Any write to a count byte resets the prescaler while it is assigned. The overflow flag is sticky. The interrupt output is that flag gated by an enable bit.

Top module: `tmr_presc`

## Requirements
- R1: After reset, the count is 0x0000, the control byte reads 0x00, and the status byte reads 0x00. irq_o is low.
- R2: The register addresses are 0 = count low, 1 = count high, 2 = control and 3 = status. The control byte bits are: [7] run, [6] 8-bit mode, [5] external source, [4] falling edge, [3] prescaler bypass, [2:0] ratio. The control byte reads back exactly as written. The status byte has the flag in [0] and the interrupt enable in [1].
- R3: When bit 3 is 0, the counter advances once per 2^(ratio+1) source events. This gives ratios from 1:2 up to 1:256.
- R4: When bit 3 is 1, the counter advances once per source event.
- R5: While the prescaler is assigned, a write to either count byte resets the prescaler count to zero and leaves the control byte unchanged. While the prescaler is bypassed, such a write leaves the prescaler count unchanged.
- R6: In 8-bit mode only the low byte counts. The overflow flag sets when the low byte wraps from 0xFF to 0x00, and the high byte keeps its value.
- R7: In 16-bit mode the low byte carries into the high byte. The flag sets only when the count wraps from 0xFFFF to 0x0000.
- R8: The flag stays set until software writes the status byte with bit 0 = 0. Writing 1 to bit 0 leaves the flag as it is.
- R9: irq_o is the flag AND the enable bit. Clearing the enable bit drops irq_o but leaves the flag set.
- R10: A write to the high byte goes only into a holding register. A write to the low byte loads {holding, data} into the count. A read of the low byte latches the count's high byte, and address 1 reads back that latch.
- R11: The external input passes through two synchronising flops. Bit 4 selects whether rising edges (0) or falling edges (1) count. In external mode tick_i is ignored.
- R12: When run = 0, neither the counter nor the prescaler advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (latches high byte on a low-byte read) |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| tick_i | input | 1 | Internal count tick, one cycle per event |
| ext_cnt_i | input | 1 | Asynchronous external count input |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
Several prescaler ratios are checked on both sides of their division boundary, including 1:256. A wrong mask shows up there as a count that is one step early or one step late. The bench leaves a partial prescaler count in place and then writes the count register, once with the prescaler assigned and once with it bypassed. A design that ignored the clear, or cleared while bypassed, would need a different number of ticks to reach the next increment. Both wrap widths are tested next to a plain 0x00FF to 0x0100 carry. This catches a flag raised on a byte wrap in 16-bit mode, and a carry leaking into the high byte in 8-bit mode. Further tests cover a prescaler that keeps counting while stopped, a read latch that follows the live count, and edge selection that counts the wrong edge.

// File: rtl/tmr_presc_pkg.sv
package tmr_presc_pkg;
  typedef enum logic [1:0] {
    REG_CNT_LO = 2'd0,
    REG_CNT_HI = 2'd1,
    REG_CTRL   = 2'd2,
    REG_STAT   = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic       run;
    logic       mode8;
    logic       ext_src;
    logic       fall_edge;
    logic       bypass;
    logic [2:0] ratio;
  } ctrl_t;
endpackage

// File: rtl/tmr_edge_sel.sv
module tmr_edge_sel #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  input  logic tick_i,
  input  logic ext_src_i,
  input  logic fall_i,
  input  logic run_i,
  output logic event_o
);
  logic [SYNC_STAGES:0] sh_q;
  logic                 rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], ext_i};
  end

  // newest synchronised sample vs. the one before it
  assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  assign fall = ~sh_q[SYNC_STAGES-1] & sh_q[SYNC_STAGES];

  assign event_o = run_i & (ext_src_i ? (fall_i ? fall : rise) : tick_i);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PRE_W = 8,
  localparam int unsigned RW   = $clog2(PRE_W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ev_i,
  input  logic          bypass_i,
  input  logic [RW-1:0] ratio_i,
  input  logic          clr_i,
  output logic          inc_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W:0]   mask_w;
  logic [PRE_W-1:0] mask;
  logic             full;

  // divide by 2^(ratio+1): low ratio+1 bits all ones
  assign mask_w = ({{(PRE_W-1){1'b0}}, 2'b10} << ratio_i) - 1'b1;
  assign mask   = mask_w[PRE_W-1:0];
  assign full   = (cnt_q & mask) == mask;
  assign inc_o  = bypass_i ? ev_i : (ev_i & full);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!bypass_i) begin
      if (clr_i)                cnt_q <= '0;
      else if (ev_i)            cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned DW = 8,
  localparam int unsigned CW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          mode8_i,
  input  logic          hi_we_i,
  input  logic          lo_we_i,
  input  logic          lo_rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [CW-1:0] cnt_o,
  output logic [DW-1:0] hi_rd_o,
  output logic          ovf_o
);
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] hold_q, lat_q;
  logic          step;

  assign step  = inc_i & ~lo_we_i;
  assign ovf_o = step & (mode8_i ? (&cnt_q[DW-1:0]) : (&cnt_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_q <= '0;
      lat_q  <= '0;
    end else begin
      if (hi_we_i) hold_q <= wdata_i;
      if (lo_rd_i) lat_q  <= cnt_q[CW-1:DW];
      if (lo_we_i)      cnt_q <= {hold_q, wdata_i};
      else if (step) begin
        if (mode8_i)    cnt_q[DW-1:0] <= cnt_q[DW-1:0] + 1'b1;
        else            cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign hi_rd_o = lat_q;
endmodule

// File: rtl/tmr_presc.sv
module tmr_presc
  import tmr_presc_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned PRE_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          tick_i,
  input  logic          ext_cnt_i,
  output logic          irq_o
);
  localparam int unsigned CW = 2 * DW;

  ctrl_t         ctrl_q;
  logic          flag_q, ie_q;
  logic          ev, inc, ovf;
  logic [CW-1:0] cnt;
  logic [DW-1:0] hi_lat;
  logic          wr_lo, wr_hi, wr_ctrl, wr_stat;

  assign wr_lo   = wr_en_i & (addr_i == REG_CNT_LO);
  assign wr_hi   = wr_en_i & (addr_i == REG_CNT_HI);
  assign wr_ctrl = wr_en_i & (addr_i == REG_CTRL);
  assign wr_stat = wr_en_i & (addr_i == REG_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[7:0]);
      if (wr_stat) ie_q   <= wdata_i[1];
      // hardware set wins over a software clear
      if (ovf)                       flag_q <= 1'b1;
      else if (wr_stat && !wdata_i[0]) flag_q <= 1'b0;
    end
  end

  tmr_edge_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ext_i     (ext_cnt_i),
    .tick_i    (tick_i),
    .ext_src_i (ctrl_q.ext_src),
    .fall_i    (ctrl_q.fall_edge),
    .run_i     (ctrl_q.run),
    .event_o   (ev)
  );

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev),
    .bypass_i (ctrl_q.bypass),
    .ratio_i  (ctrl_q.ratio),
    .clr_i    (wr_lo | wr_hi),
    .inc_o    (inc)
  );

  tmr_counter #(.DW(DW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (inc),
    .mode8_i (ctrl_q.mode8),
    .hi_we_i (wr_hi),
    .lo_we_i (wr_lo),
    .lo_rd_i (rd_en_i & (addr_i == REG_CNT_LO)),
    .wdata_i (wdata_i),
    .cnt_o   (cnt),
    .hi_rd_o (hi_lat),
    .ovf_o   (ovf)
  );

  always_comb begin
    unique case (addr_i)
      REG_CNT_LO: rdata_o = cnt[DW-1:0];
      REG_CNT_HI: rdata_o = hi_lat;
      REG_CTRL:   rdata_o = DW'(ctrl_q);
      default:    rdata_o = {{(DW-2){1'b0}}, ie_q, flag_q};
    endcase
  end

  assign irq_o = flag_q & ie_q;
endmodule

// File: rtl/tmr_presc_chk.sv
module tmr_presc_chk #(
  parameter int unsigned DW    = 8,
  parameter int unsigned PRE_W = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [1:0]    addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [7:0]    ctrl_i,
  input logic          flag_i,
  input logic          irq_i,
  input logic          inc_i,
  input logic [2*DW-1:0] cnt_i,
  input logic [PRE_W-1:0] pre_i
);
  logic wr_lo, wr_cnt;
  assign wr_lo  = wr_en_i && addr_i == 2'd0;
  assign wr_cnt = wr_en_i && (addr_i == 2'd0 || addr_i == 2'd1);

  // R3
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_lo && !inc_i |=> $stable(cnt_i));

  // R5
  pre_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt && !ctrl_i[3] |=> pre_i == '0);

  // R6
  hi_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[6] && !wr_lo |=> $stable(cnt_i[2*DW-1:DW]));

  // R7
  ovf16_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !ctrl_i[6] && (&cnt_i) && !wr_lo |=> flag_i && cnt_i == '0);

  // R8
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_i && !(wr_en_i && addr_i == 2'd3 && !wdata_i[0]) |=> flag_i);

  // R9
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_i && wr_en_i && addr_i == 2'd3 && wdata_i[1:0] == 2'b01 |=> flag_i && !irq_i);

  // R12
  halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[7] && !wr_cnt |=> $stable(cnt_i) && $stable(pre_i));
endmodule

bind tmr_presc tmr_presc_chk #(.DW(DW), .PRE_W(PRE_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .ctrl_i  (ctrl_q),
  .flag_i  (flag_q),
  .irq_i   (irq_o),
  .inc_i   (inc),
  .cnt_i   (cnt),
  .pre_i   (u_pre.cnt_q)
);

// File: tb/tmr_presc_tb.sv
`timescale 1ns/1ps
module tmr_presc_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       tick = 1'b0, ext = 1'b0;
  logic       irq;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  tmr_presc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .tick_i(tick), .ext_cnt_i(ext), .irq_o(irq)
  );

  typedef struct packed {
    logic [7:0] ctrl;
    logic [8:0] ticks;
    logic [7:0] exp;
  } vec_t;

  // ratio and bypass vectors: {ctrl, ticks, expected count low}
  localparam vec_t VECS [10] = '{
    '{8'h80, 9'd1,   8'd0},
    '{8'h80, 9'd2,   8'd1},
    '{8'h81, 9'd7,   8'd1},
    '{8'h81, 9'd8,   8'd2},
    '{8'h82, 9'd24,  8'd3},
    '{8'h84, 9'd64,  8'd2},
    '{8'h87, 9'd255, 8'd0},
    '{8'h87, 9'd256, 8'd1},
    '{8'h88, 9'd5,   8'd5},
    '{8'hC8, 9'd10,  8'd10}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic ext_lvl(input logic v);
    @(negedge clk); ext = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic clr_cnt();
    wr(2'd1, 8'h00); wr(2'd0, 8'h00);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); chk("R1 cnt lo", v, 8'h00);
    rd(2'd1, v); chk("R1 cnt hi", v, 8'h00);
    rd(2'd2, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd3, v); chk("R1 stat", v, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // R2 control read-back
    wr(2'd2, 8'h5A); rd(2'd2, v); chk("R2 ctrl rb", v, 8'h5A);

    // R3 R4 table
    foreach (VECS[k]) begin
      wr(2'd2, VECS[k].ctrl);
      clr_cnt();
      ticks(int'(VECS[k].ticks));
      rd(2'd0, v);
      chk(VECS[k].ctrl[3] ? "R4 bypass" : "R3 ratio", v, VECS[k].exp);
    end

    // R5 clear while assigned, div4
    wr(2'd2, 8'h81); clr_cnt(); ticks(3);
    wr(2'd0, 8'h00); ticks(3);
    rd(2'd0, v); chk("R5 clear on write", v, 8'h00);
    ticks(1);
    rd(2'd0, v); chk("R5 after clear", v, 8'h01);
    rd(2'd2, v); chk("R5 ctrl kept", v, 8'h81);
    // R5 write while bypassed keeps prescaler
    clr_cnt(); ticks(2);
    wr(2'd2, 8'h89); wr(2'd0, 8'h00); wr(2'd2, 8'h81);
    ticks(2);
    rd(2'd0, v); chk("R5 bypass no clear", v, 8'h01);

    // R6 8-bit overflow
    wr(2'd3, 8'h00); wr(2'd2, 8'hC8);
    wr(2'd1, 8'h12); wr(2'd0, 8'hFE);
    ticks(1);
    rd(2'd3, v); chk("R6 no flag at FF", v, 8'h00);
    ticks(1);
    rd(2'd0, v); chk("R6 lo wrap", v, 8'h00);
    rd(2'd1, v); chk("R6 hi kept", v, 8'h12);
    rd(2'd3, v); chk("R6 flag", v, 8'h01);

    // R7 16-bit carry and overflow
    wr(2'd3, 8'h00); wr(2'd2, 8'h88);
    wr(2'd1, 8'h00); wr(2'd0, 8'hFF); ticks(1);
    rd(2'd0, v); chk("R7 carry lo", v, 8'h00);
    rd(2'd1, v); chk("R7 carry hi", v, 8'h01);
    rd(2'd3, v); chk("R7 no flag on byte wrap", v, 8'h00);
    wr(2'd1, 8'hFF); wr(2'd0, 8'hFF); ticks(1);
    rd(2'd0, v); chk("R7 wrap lo", v, 8'h00);
    rd(2'd1, v); chk("R7 wrap hi", v, 8'h00);
    rd(2'd3, v); chk("R7 flag", v, 8'h01);

    // R8 R9 flag and mask
    wr(2'd3, 8'h03);
    rd(2'd3, v); chk("R8 write 1 keeps flag", v, 8'h03);
    chk("R9 irq on", {7'd0, irq}, 8'h01);
    wr(2'd3, 8'h01);
    rd(2'd3, v); chk("R9 mask keeps flag", v, 8'h01);
    chk("R9 irq masked", {7'd0, irq}, 8'h00);
    wr(2'd3, 8'h00);
    rd(2'd3, v); chk("R8 flag cleared", v, 8'h00);

    // R10 holding register and read latch
    wr(2'd2, 8'h08);
    wr(2'd1, 8'h34); wr(2'd0, 8'h56); wr(2'd1, 8'hAB);
    rd(2'd0, v); chk("R10 lo before load", v, 8'h56);
    rd(2'd1, v); chk("R10 hi held", v, 8'h34);
    wr(2'd0, 8'hCD);
    rd(2'd0, v); chk("R10 lo loaded", v, 8'hCD);
    rd(2'd1, v); chk("R10 hi loaded", v, 8'hAB);
    wr(2'd2, 8'h88); wr(2'd1, 8'h00); wr(2'd0, 8'hFF);
    rd(2'd0, v); ticks(1);
    rd(2'd1, v); chk("R10 latched hi", v, 8'h00);
    rd(2'd0, v); rd(2'd1, v); chk("R10 relatch hi", v, 8'h01);

    // R11 external edges
    wr(2'd2, 8'hA8); clr_cnt();
    ext_lvl(1'b1);
    rd(2'd0, v); chk("R11 rising counted", v, 8'h01);
    ext_lvl(1'b0);
    rd(2'd0, v); chk("R11 falling ignored", v, 8'h01);
    ticks(2);
    rd(2'd0, v); chk("R11 tick ignored", v, 8'h01);
    wr(2'd2, 8'hB8);
    ext_lvl(1'b1);
    rd(2'd0, v); chk("R11 rise ignored in fall mode", v, 8'h01);
    ext_lvl(1'b0);
    rd(2'd0, v); chk("R11 falling counted", v, 8'h02);

    // R12 halt
    wr(2'd2, 8'h08); clr_cnt(); ticks(3);
    rd(2'd0, v); chk("R12 counter halted", v, 8'h00);
    wr(2'd2, 8'h80); clr_cnt(); ticks(1);
    wr(2'd2, 8'h00); ticks(3);
    wr(2'd2, 8'h80); ticks(1);
    rd(2'd0, v); chk("R12 prescaler halted", v, 8'h01);

    report();
  end
endmodule